// File: doc/BRIEF.md
# Single-Frame Receive Buffer

This block sits between a network byte stream and a host register port. It holds one received Ethernet frame at a time. On the network side a frame arrives as a run of bytes, each marked by a valid strobe, with start and end markers on the first and last byte. A frame is taken only when the block is idle: the busy flag must be clear and the stored count must be below capacity. Once taken, the frame's bytes go into a single-port RAM. When the last byte arrives, the stored length becomes visible and a one-cycle done pulse fires. A done flag is also set in the control word.

Software reads the stored length from a count register. It then drains the frame through a byte-wide pop register: each pop returns the next byte and lowers the visible count by one. Reads are answered one cycle after the strobe, marked by a read-valid signal. Software re-arms the block by writing the control word. This clears the done flag and recomputes busy, which lets the next frame in.

Top module: `rx_frame_buf`

## Requirements
- R1: After reset, busy is set, `net_ready` is low, and both the count register and the control word read zero. A write of any value to the control offset (0x14) with the done flag clear releases busy and raises `net_ready`.
- R2: `net_ready` is high only while busy is clear and the stored count is below capacity. A frame whose start byte arrives while `net_ready` is low is dropped whole: no done pulse fires and the count register keeps its value.
- R3: Accepting a frame sets busy, restarts the count and resets the read position to the first byte. Bytes are stored in arrival order, and idle cycles with `net_valid` low inside a frame add no bytes.
- R4: One cycle after the end-marked byte is accepted, `rx_done` is high for exactly one cycle. At the same time the count register (offset 0x0C) shows the frame length and bit 1 of the control word (offset 0x14) reads 1. A frame of a single byte, with start and end on the same byte, is handled the same way.
- R5: A read of the pop offset (0x1C) while the count is nonzero returns, in bits 7:0 with upper bits zero, the byte at the read position. It lowers the count by one and advances the position. Every read strobe is answered by `host_rvalid` exactly one cycle later.
- R6: A read of the pop offset while the count is zero returns zero and leaves the count unchanged.
- R7: Bytes beyond capacity are dropped. The count saturates at capacity, and the stored bytes are the first capacity bytes of the frame.
- R8: While the count is at capacity, `net_ready` stays low and frames are refused even after busy is cleared. `net_ready` returns as soon as a pop lowers the count.
- R9: A control write with bit 1 set clears the done flag. After any control write, busy equals the resulting done flag, so a write with bit 1 clear leaves the block busy while the flag is set.
- R10: Reads of offsets other than count, pop and control return zero. All offsets are decoded on the low six address bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| net_valid | input | 1 | Byte on `net_data` is valid this cycle |
| net_sof | input | 1 | Valid byte is the first of a frame |
| net_eof | input | 1 | Valid byte is the last of a frame |
| net_data | input | 8 | Received byte |
| net_ready | output | 1 | A new frame would be accepted |
| rx_done | output | 1 | One-cycle pulse: a frame has been stored |
| host_rd | input | 1 | Register read strobe |
| host_wr | input | 1 | Register write strobe |
| host_addr | input | 6 | Register byte offset |
| host_wdata | input | 32 | Write data |
| host_rdata | output | 32 | Read data, valid with `host_rvalid` |
| host_rvalid | output | 1 | Read answer, one cycle after `host_rd` |

## Verification
The bench builds the block with a capacity of 24 bytes instead of 1514. This brings truncation of an oversize frame, the saturated count and refusal while full within a few dozen cycles, and a complete drain of a full buffer stays short. The bound checker takes the same capacity, so its bound on the count and its accept and refuse properties are exercised at the saturation edge.

// File: rtl/rxb_pkg.sv
package rxb_pkg;
  localparam int unsigned HOST_AW = 6;
  localparam logic [HOST_AW-1:0] OFS_RX_COUNT = 6'h0C;
  localparam logic [HOST_AW-1:0] OFS_CTRL     = 6'h14;
  localparam logic [HOST_AW-1:0] OFS_RX_POP   = 6'h1C;
  localparam int unsigned FLAG_RXDONE = 1;

  typedef enum logic [1:0] {
    ING_IDLE,
    ING_CAPTURE,
    ING_DISCARD
  } ing_state_e;
endpackage

// File: rtl/rxb_ram.sv
module rxb_ram #(
  parameter int unsigned DEPTH = 1514,
  parameter int unsigned AW    = 11,
  parameter int unsigned W     = 8
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] addr,
  input  logic [W-1:0]  wdata,
  output logic [W-1:0]  rdata
);
  logic [W-1:0] mem [0:DEPTH-1];

  // single port, registered read, written for block RAM inference
  always_ff @(posedge clk) begin
    if (we) mem[addr] <= wdata;
    rdata <= mem[addr];
  end
endmodule

// File: rtl/rxb_ingest.sv
module rxb_ingest import rxb_pkg::*; #(
  parameter int unsigned CAP = 1514,
  parameter int unsigned CW  = 11,
  parameter int unsigned AW  = 11
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          net_valid,
  input  logic          net_sof,
  input  logic          net_eof,
  input  logic          ready_in,
  output logic          acc,
  output logic          we,
  output logic [AW-1:0] widx,
  output logic          fin,
  output logic [CW-1:0] fin_len,
  output logic          capturing
);
  localparam logic [CW-1:0] CAP_C = CW'(CAP);

  ing_state_e   state_q;
  logic [CW-1:0] wcnt_q;
  logic          in_cap;
  logic          room;

  assign room      = wcnt_q < CAP_C;
  assign acc       = (state_q == ING_IDLE) && net_valid && net_sof && ready_in;
  assign in_cap    = (state_q == ING_CAPTURE) && net_valid;
  assign capturing = state_q == ING_CAPTURE;
  // R7: surplus bytes past capacity are not written
  assign we        = acc || (in_cap && room);
  assign widx      = acc ? '0 : wcnt_q[AW-1:0];
  assign fin       = (acc || in_cap) && net_eof;
  assign fin_len   = acc ? CW'(1) : (room ? wcnt_q + 1'b1 : wcnt_q);

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ING_IDLE;
      wcnt_q  <= '0;
    end else begin
      case (state_q)
        ING_IDLE: begin
          if (net_valid && net_sof && !net_eof) begin
            if (ready_in) begin
              state_q <= ING_CAPTURE;
              wcnt_q  <= CW'(1);
            end else begin
              // R2: refused frame is skipped up to its end marker
              state_q <= ING_DISCARD;
            end
          end
        end
        ING_CAPTURE: begin
          if (net_valid) begin
            if (room) wcnt_q <= wcnt_q + 1'b1;
            if (net_eof) state_q <= ING_IDLE;
          end
        end
        ING_DISCARD: begin
          if (net_valid && net_eof) state_q <= ING_IDLE;
        end
        default: state_q <= ING_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/rxb_host.sv
module rxb_host import rxb_pkg::*; #(
  parameter int unsigned CAP = 1514,
  parameter int unsigned CW  = 11,
  parameter int unsigned AW  = 11,
  parameter int unsigned DW  = 32
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               host_rd,
  input  logic               host_wr,
  input  logic [HOST_AW-1:0] host_addr,
  input  logic [DW-1:0]      host_wdata,
  input  logic               acc,
  input  logic               fin,
  input  logic [CW-1:0]      fin_len,
  input  logic               capturing,
  input  logic [7:0]         ram_q,
  output logic [AW-1:0]      rd_ptr,
  output logic               busy,
  output logic [CW-1:0]      rx_count,
  output logic               ready,
  output logic               done_pulse,
  output logic [DW-1:0]      rdata,
  output logic               rvalid
);
  localparam logic [CW-1:0] CAP_C = CW'(CAP);

  logic          busy_q, flag_q, flag_n, pop_q, rvalid_q, done_q;
  logic [CW-1:0] cnt_q;
  logic [AW-1:0] ptr_q;
  logic [DW-1:0] reg_q, rd_word;
  logic          sel_cnt, sel_ctl, sel_pop, pop_go, ctl_wr;
  logic          unused_wbits;

  assign unused_wbits = ^host_wdata;
  assign sel_cnt = host_addr == OFS_RX_COUNT;
  assign sel_ctl = host_addr == OFS_CTRL;
  assign sel_pop = host_addr == OFS_RX_POP;
  // R5 / R6: pop only acts on a nonzero count
  assign pop_go  = host_rd && sel_pop && (cnt_q != '0) && !acc;
  assign ctl_wr  = host_wr && sel_ctl;

  // R9: clear by bit 1, a finishing frame wins
  always_comb begin
    flag_n = flag_q;
    if (ctl_wr && host_wdata[FLAG_RXDONE]) flag_n = 1'b0;
    if (fin) flag_n = 1'b1;
  end

  // R10: unmapped offsets read zero
  always_comb begin
    rd_word = '0;
    if (sel_cnt)      rd_word[CW-1:0]    = cnt_q;
    else if (sel_ctl) rd_word[FLAG_RXDONE] = flag_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q   <= 1'b1;  // R1
      flag_q   <= 1'b0;
      cnt_q    <= '0;
      ptr_q    <= '0;
      pop_q    <= 1'b0;
      rvalid_q <= 1'b0;
      done_q   <= 1'b0;
      reg_q    <= '0;
    end else begin
      rvalid_q <= host_rd;
      pop_q    <= pop_go;
      done_q   <= fin;
      reg_q    <= rd_word;
      flag_q   <= flag_n;
      if (acc || capturing || fin) busy_q <= 1'b1;
      else if (ctl_wr)             busy_q <= flag_n;
      if (fin) begin
        cnt_q <= fin_len;
        ptr_q <= '0;
      end else if (acc) begin
        cnt_q <= '0;
        ptr_q <= '0;
      end else if (pop_go) begin
        cnt_q <= cnt_q - 1'b1;
        ptr_q <= ptr_q + 1'b1;
      end
    end
  end

  assign rd_ptr     = ptr_q;
  assign busy       = busy_q;
  assign rx_count   = cnt_q;
  assign ready      = !busy_q && (cnt_q < CAP_C);
  assign done_pulse = done_q;
  assign rvalid     = rvalid_q;
  assign rdata      = pop_q ? {{(DW-8){1'b0}}, ram_q} : reg_q;
endmodule

// File: rtl/rx_frame_buf.sv
module rx_frame_buf import rxb_pkg::*; #(
  parameter int unsigned CAP = 1514,
  parameter int unsigned DW  = 32
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               net_valid,
  input  logic               net_sof,
  input  logic               net_eof,
  input  logic [7:0]         net_data,
  output logic               net_ready,
  output logic               rx_done,
  input  logic               host_rd,
  input  logic               host_wr,
  input  logic [HOST_AW-1:0] host_addr,
  input  logic [DW-1:0]      host_wdata,
  output logic [DW-1:0]      host_rdata,
  output logic               host_rvalid
);
  localparam int unsigned CW = $clog2(CAP + 1);
  localparam int unsigned AW = $clog2(CAP);

  logic          acc, we, fin, capturing, busy;
  logic [AW-1:0] widx, rd_ptr, ram_addr;
  logic [CW-1:0] fin_len, rx_count;
  logic [7:0]    ram_q;

  rxb_ingest #(.CAP(CAP), .CW(CW), .AW(AW)) u_ingest (
    .clk(clk), .rst(rst),
    .net_valid(net_valid), .net_sof(net_sof), .net_eof(net_eof),
    .ready_in(net_ready),
    .acc(acc), .we(we), .widx(widx), .fin(fin), .fin_len(fin_len),
    .capturing(capturing)
  );

  assign ram_addr = (acc || capturing) ? widx : rd_ptr;

  rxb_ram #(.DEPTH(CAP), .AW(AW), .W(8)) u_ram (
    .clk(clk), .we(we), .addr(ram_addr), .wdata(net_data), .rdata(ram_q)
  );

  rxb_host #(.CAP(CAP), .CW(CW), .AW(AW), .DW(DW)) u_host (
    .clk(clk), .rst(rst),
    .host_rd(host_rd), .host_wr(host_wr), .host_addr(host_addr),
    .host_wdata(host_wdata),
    .acc(acc), .fin(fin), .fin_len(fin_len), .capturing(capturing),
    .ram_q(ram_q),
    .rd_ptr(rd_ptr), .busy(busy), .rx_count(rx_count),
    .ready(net_ready), .done_pulse(rx_done),
    .rdata(host_rdata), .rvalid(host_rvalid)
  );
endmodule

// File: rtl/rxb_chk.sv
module rxb_chk import rxb_pkg::*; #(
  parameter int unsigned CAP = 1514,
  parameter int unsigned CW  = 11,
  parameter int unsigned DW  = 32
) (
  input logic               clk,
  input logic               rst,
  input logic               net_valid,
  input logic               net_sof,
  input logic               net_ready,
  input logic               rx_done,
  input logic               host_rd,
  input logic [HOST_AW-1:0] host_addr,
  input logic [DW-1:0]      host_rdata,
  input logic               host_rvalid,
  input logic               busy,
  input logic [CW-1:0]      cnt
);
  logic start_ok;
  assign start_ok = net_sof && net_valid && net_ready;

  // R2
  refuse_chk: assert property (@(posedge clk) disable iff (rst)
    (net_sof && net_valid && !net_ready) |=> !rx_done);
  // R3
  accept_busy_chk: assert property (@(posedge clk) disable iff (rst)
    start_ok |=> (busy && !net_ready));
  // R4
  done_once_chk: assert property (@(posedge clk) disable iff (rst)
    rx_done |=> !rx_done);
  // R4
  done_busy_chk: assert property (@(posedge clk) disable iff (rst)
    rx_done |-> busy);
  // R7
  cap_bound_chk: assert property (@(posedge clk) disable iff (rst)
    cnt <= CW'(CAP));
  // R5
  pop_dec_chk: assert property (@(posedge clk) disable iff (rst)
    (host_rd && host_addr == OFS_RX_POP && cnt != '0 && !start_ok)
      |=> cnt == $past(cnt) - 1'b1);
  // R5
  rvalid_chk: assert property (@(posedge clk) disable iff (rst)
    host_rd |=> host_rvalid);
  // R6
  empty_pop_chk: assert property (@(posedge clk) disable iff (rst)
    (host_rd && host_addr == OFS_RX_POP && cnt == '0 && !busy && !start_ok)
      |=> (host_rdata == '0 && cnt == '0));
endmodule

bind rx_frame_buf rxb_chk #(.CAP(CAP), .CW(CW), .DW(DW)) u_chk (
  .clk(clk), .rst(rst), .net_valid(net_valid), .net_sof(net_sof),
  .net_ready(net_ready), .rx_done(rx_done), .host_rd(host_rd),
  .host_addr(host_addr), .host_rdata(host_rdata), .host_rvalid(host_rvalid),
  .busy(busy), .cnt(rx_count)
);

// File: tb/test_rx_frame_buf.sv
module test_rx_frame_buf;
  localparam int CLK_PERIOD = 10;
  localparam int TB_CAP = 24;
  localparam logic [5:0] A_CNT = 6'h0C, A_CTL = 6'h14, A_POP = 6'h1C;

  logic clk = 0, rst = 1;
  logic net_valid = 0, net_sof = 0, net_eof = 0;
  logic [7:0] net_data = 0;
  logic net_ready, rx_done;
  logic host_rd = 0, host_wr = 0;
  logic [5:0] host_addr = 0;
  logic [31:0] host_wdata = 0, host_rdata;
  logic host_rvalid;

  int checks = 0, errors = 0;
  logic [31:0] exp_q[$];
  string tag_q[$];
  logic [7:0] frame_mem [0:TB_CAP-1];
  int mdl_cnt = 0, mdl_rp = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  rx_frame_buf #(.CAP(TB_CAP), .DW(32)) i_rx_frame_buf (
    .clk(clk), .rst(rst), .net_valid(net_valid), .net_sof(net_sof),
    .net_eof(net_eof), .net_data(net_data), .net_ready(net_ready),
    .rx_done(rx_done), .host_rd(host_rd), .host_wr(host_wr),
    .host_addr(host_addr), .host_wdata(host_wdata),
    .host_rdata(host_rdata), .host_rvalid(host_rvalid)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // monitor: scoreboard side
  always @(negedge clk) begin
    if (!rst && host_rvalid) begin
      if (exp_q.size() == 0) check(0, "R5 unexpected read answer", int'(host_rdata), -1);
      else begin
        logic [31:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        check(host_rdata == e, t, int'(host_rdata), int'(e));
      end
    end
  end

  task automatic read_reg(input logic [5:0] a, input logic [31:0] e, input string tag);
    @(negedge clk);
    host_rd = 1; host_addr = a;
    exp_q.push_back(e); tag_q.push_back(tag);
    @(negedge clk);
    host_rd = 0;
  endtask

  task automatic pop(input string tag);
    logic [31:0] e;
    if (mdl_cnt > 0) begin
      e = {24'b0, frame_mem[mdl_rp]};
      mdl_rp++; mdl_cnt--;
    end else e = 0;
    read_reg(A_POP, e, tag);
  endtask

  task automatic write_ctl(input logic [31:0] v);
    @(negedge clk);
    host_wr = 1; host_addr = A_CTL; host_wdata = v;
    @(negedge clk);
    host_wr = 0;
  endtask

  task automatic send_frame(input int n, input logic [7:0] base, input bit gap,
                            input bit exp_acc, input string tag);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (gap && i == 1) begin
        net_valid = 0; net_sof = 0; net_eof = 0;
        @(negedge clk);
      end
      net_valid = 1; net_sof = (i == 0); net_eof = (i == n - 1);
      net_data = base + 8'(i);
    end
    @(negedge clk);
    net_valid = 0; net_sof = 0; net_eof = 0;
    check(rx_done == exp_acc, {tag, " done pulse"}, int'(rx_done), int'(exp_acc));
    @(negedge clk);
    check(rx_done == 0, {tag, " done one cycle"}, int'(rx_done), 0);
    if (exp_acc) begin
      mdl_cnt = (n < TB_CAP) ? n : TB_CAP;
      mdl_rp = 0;
      for (int i = 0; i < mdl_cnt; i++) frame_mem[i] = base + 8'(i);
    end
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    check(0, "watchdog expired", 0, 1);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    // R1 reset state
    check(net_ready == 0, "R1 ready after reset", int'(net_ready), 0);
    read_reg(A_CNT, 0, "R1 count after reset");
    read_reg(A_CTL, 0, "R1 ctrl after reset");
    write_ctl(0);
    check(net_ready == 1, "R1 armed by control write", int'(net_ready), 1);

    // R4 normal frame
    send_frame(5, 8'h10, 0, 1, "R4 frame5");
    check(net_ready == 0, "R3 busy after accept", int'(net_ready), 0);
    read_reg(A_CNT, mdl_cnt, "R4 count");
    read_reg(A_CTL, 2, "R4 done flag");
    pop("R5 pop0"); pop("R5 pop1");
    read_reg(A_CNT, mdl_cnt, "R5 count after pops");
    // R2 refused while busy
    send_frame(3, 8'h80, 0, 0, "R2 busy refuse");
    read_reg(A_CNT, mdl_cnt, "R2 count kept");
    pop("R3 order a"); pop("R3 order b"); pop("R3 order c");
    pop("R6 empty pop");
    read_reg(A_CNT, 0, "R6 count unchanged");

    // R9 control writes
    write_ctl(1);
    read_reg(A_CTL, 2, "R9 flag kept");
    check(net_ready == 0, "R9 still busy", int'(net_ready), 0);
    write_ctl(2);
    read_reg(A_CTL, 0, "R9 flag cleared");
    check(net_ready == 1, "R9 busy released", int'(net_ready), 1);

    // single byte frame
    send_frame(1, 8'h55, 0, 1, "R4 single byte");
    read_reg(A_CNT, 1, "R4 single count");
    pop("R4 single pop");
    write_ctl(2);

    // R3 restart on accept with leftover bytes, gap inside frame
    send_frame(4, 8'h20, 0, 1, "R3 frameA");
    pop("R3 frameA pop");
    write_ctl(2);
    check(net_ready == 1, "R2 ready with leftover", int'(net_ready), 1);
    send_frame(3, 8'h40, 1, 1, "R3 frameB gap");
    read_reg(A_CNT, 3, "R3 count restart");
    pop("R3 read pointer reset"); pop("R3 b1"); pop("R3 b2");
    write_ctl(2);

    // R7 truncation, R8 full
    send_frame(TB_CAP + 6, 8'hA0, 1, 1, "R7 oversize");
    read_reg(A_CNT, TB_CAP, "R7 saturated count");
    write_ctl(2);
    check(net_ready == 0, "R8 full blocks ready", int'(net_ready), 0);
    send_frame(2, 8'h33, 0, 0, "R8 full refuse");
    read_reg(A_CNT, TB_CAP, "R8 count kept");
    for (int i = 0; i < TB_CAP; i++) pop("R7 drain");
    check(net_ready == 1, "R8 ready after drain", int'(net_ready), 1);
    pop("R6 empty after drain");

    // R10 unmapped offsets
    read_reg(6'h00, 0, "R10 offset 0x00");
    read_reg(6'h08, 0, "R10 offset 0x08");

    repeat (3) @(negedge clk);
    check(exp_q.size() == 0, "R5 all reads answered", exp_q.size(), 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule